// File: doc/BRIEF.md
# Line Memory Read-Validity Monitor

This block sits beside a dual-port serial line memory whose write and read sides share one clock. Each side has its own active-low clear input, which returns its address pointer to cell 0, and its own active-high pause input, which freezes the pointer for that cycle. The monitor keeps its own copy of both pointers and works out, every cycle, how far the write pointer leads the read pointer. The lead is taken modulo the line length, so a write pointer that has wrapped past the end of the line still counts as leading.

A lead that is not zero but falls below a minimum gap is a hazard. The write still lands, but the word read in that cycle cannot be trusted. After the hazard clears, reads stay untrustworthy for a fixed number of further read cycles. Only cycles in which the read side actually reads count toward that recovery. The hazard rule is suspended in any cycle where either side is cleared or paused, and it never applies when the read pointer is equal to or ahead of the write pointer.

A second, free-running reference clock watches the shared clock. If the shared clock holds one level for longer than a set number of reference ticks, the memory contents are lost. The monitor then raises a flag that stays up, and keeps reads marked invalid, until both sides have been cleared at least once. The flag `read_valid` is registered so that it lines up with the memory's registered read data.

Top module: `line_mem_read_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `read_valid`, `violation` and `need_reset` are all 0. Both tracked pointers start at cell 0.
- R2: A pointer goes to 0 in a cycle where its clear input is low. Otherwise it advances by one in a cycle where its pause input is low, going from LINE_LEN-1 back to 0, and it holds in a cycle where its pause input is high. With a lead of at least MIN_GAP, `read_valid` is 1 one cycle after each read cycle.
- R3: A cycle is a hazard cycle when both clear inputs are high, both pause inputs are low, and the lead (write minus read, modulo LINE_LEN) is between 1 and MIN_GAP-1. `read_valid` is 0 in the cycle that follows it.
- R4: `violation` is high for exactly one cycle, one cycle after the first hazard cycle of each unbroken run of hazard cycles. Any cycle that is not a hazard cycle ends a run.
- R5: After a run of hazard cycles, `read_valid` stays 0 for the next RECOVER_CYCLES read cycles. A read cycle is one where `r_clear_n`=1 and `r_pause`=0. Cycles in which the read side is cleared or paused do not use up the recovery.
- R6: No hazard is flagged in a cycle where either clear input is low or either pause input is high, whatever the lead.
- R7: No hazard is flagged when the pointers are equal (lead 0), or when the read pointer is ahead, which gives a lead of at least MIN_GAP.
- R8: The lead wraps at LINE_LEN. A write pointer cleared to 0 while the read pointer sits near LINE_LEN-1 gives a small lead, and that lead is a hazard.
- R9: If `clk` holds one level for longer than STALL_TICKS periods of `ref_clk`, `need_reset` goes to 1 within four `clk` cycles after the clock resumes. While `need_reset` is 1, `read_valid` is 0 in the cycle that follows.
- R10: `need_reset` returns to 0 after the cycle in which at least one write-clear cycle and at least one read-clear cycle have both been seen since it was set. The two clears may come in either order.
- R11: `read_valid` is 0 in the cycle after one in which `r_clear_n`=0 or `r_pause`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared memory clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Free-running reference clock for stall detection |
| w_clear_n | input | 1 | Write pointer clear, active low |
| w_pause | input | 1 | Write side pause, active high |
| r_clear_n | input | 1 | Read pointer clear, active low |
| r_pause | input | 1 | Read side pause, active high |
| read_valid | output | 1 | Read data of the previous cycle can be trusted |
| violation | output | 1 | One-cycle pulse at the start of a hazard run |
| need_reset | output | 1 | Clock stall seen; both sides must be cleared |

## Verification
Two situations are hardest to reach from the ports. The first is the pointer wrap: the bench steps only the read side until its own model pointer reaches cell 1000, then clears the write side. The second is the clock stall: the bench gates its clock generator off for 400 ns with both sides paused, so that only the reference-clock detector is running. It then lets a few idle cycles pass while the flag crosses back into the memory clock domain, and only after that checks the flag and the order of the clears that release it. Recovery counting under read pauses is reached by pausing the read side in the middle of the recovery window while the write side keeps advancing.

// File: rtl/lmv_pkg.sv
package lmv_pkg;

  // Controls for one side of the line memory.
  typedef struct packed {
    logic clear_n;  // low: pointer returns to cell 0
    logic pause;    // high: pointer holds
  } side_ctl_t;

  function automatic logic side_active(input side_ctl_t c);
    return c.clear_n && !c.pause;
  endfunction

endpackage

// File: rtl/lmv_sync.sv
module lmv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lmv_ptr.sv
module lmv_ptr
  import lmv_pkg::*;
#(
  parameter int LINE_LEN = 1024
) (
  input  logic                        clk,
  input  logic                        rst,
  input  side_ctl_t                   ctl,
  output logic [$clog2(LINE_LEN)-1:0] ptr
);
  localparam int PW = $clog2(LINE_LEN);
  localparam logic [PW-1:0] LAST = PW'(LINE_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst)               ptr <= '0;
    else if (!ctl.clear_n) ptr <= '0;
    else if (!ctl.pause)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R2: a clear cycle leaves the pointer at cell 0
  a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
    !ctl.clear_n |=> ptr == '0);

  // R2: a paused, non-cleared cycle leaves the pointer unchanged
  a_r2_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (ctl.clear_n && ctl.pause) |=> $stable(ptr));
endmodule

// File: rtl/lmv_stall_det.sv
module lmv_stall_det #(
  parameter int STALL_TICKS = 20
) (
  input  logic ref_clk,
  input  logic ref_rst,
  input  logic mem_clk,
  output logic stall_tgl
);
  localparam int CW = $clog2(STALL_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STALL_TICKS);
  localparam logic [CW-1:0] ARM   = CW'(STALL_TICKS - 1);

  logic          clk_s;
  logic          clk_d;
  logic          edge_seen;
  logic [CW-1:0] cnt;

  lmv_sync #(.STAGES(2), .RST_VAL(1'b0)) u_clk_sync (
    .clk (ref_clk),
    .rst (ref_rst),
    .d   (mem_clk),
    .q   (clk_s)
  );

  assign edge_seen = clk_s ^ clk_d;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      clk_d     <= 1'b0;
      cnt       <= '0;
      stall_tgl <= 1'b0;
    end else begin
      clk_d <= clk_s;
      if (edge_seen) begin
        cnt <= '0;
      end else if (cnt != LIMIT) begin
        cnt <= cnt + 1'b1;
        if (cnt == ARM) stall_tgl <= ~stall_tgl;
      end
    end
  end

  // R9: a seen clock edge never reports a stall
  a_r9_edge_no_stall: assert property (@(posedge ref_clk) disable iff (ref_rst)
    edge_seen |=> stall_tgl == $past(stall_tgl));
endmodule

// File: rtl/lmv_recovery.sv
module lmv_recovery #(
  parameter int RECOVER_CYCLES = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic both_active,
  input  logic rd_active,
  input  logic too_close,
  input  logic need_reset,
  output logic read_valid,
  output logic violation
);
  localparam int RW = $clog2(RECOVER_CYCLES + 1);
  localparam logic [RW-1:0] RELOAD = RW'(RECOVER_CYCLES);

  logic          hazard;
  logic          hazard_d;
  logic [RW-1:0] rec_cnt;
  logic          cycle_ok;

  assign hazard   = both_active && too_close;
  assign cycle_ok = rd_active && !hazard && (rec_cnt == '0) && !need_reset;

  always_ff @(posedge clk) begin
    if (rst) begin
      hazard_d   <= 1'b0;
      rec_cnt    <= '0;
      read_valid <= 1'b0;
      violation  <= 1'b0;
    end else begin
      hazard_d   <= hazard;
      read_valid <= cycle_ok;
      violation  <= hazard && !hazard_d;
      if (hazard)                         rec_cnt <= RELOAD;
      else if (rd_active && rec_cnt != 0) rec_cnt <= rec_cnt - 1'b1;
    end
  end

  // R3: a hazard cycle yields an invalid read
  a_r3_hazard_invalid: assert property (@(posedge clk) disable iff (rst)
    hazard |=> !read_valid);

  // R4: the violation pulse lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    violation |=> !violation);

  // R5: non-read cycles do not consume recovery
  a_r5_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!hazard && !rd_active) |=> $stable(rec_cnt));

  // R9: a pending stall blocks valid reads
  a_r9_need_blocks: assert property (@(posedge clk) disable iff (rst)
    need_reset |=> !read_valid);

  // R11: no valid flag after a non-read cycle
  a_r11_idle_invalid: assert property (@(posedge clk) disable iff (rst)
    !rd_active |=> !read_valid);
endmodule

// File: rtl/line_mem_read_monitor.sv
module line_mem_read_monitor
  import lmv_pkg::*;
#(
  parameter int LINE_LEN       = 1024,
  parameter int MIN_GAP        = 256,
  parameter int RECOVER_CYCLES = 256,
  parameter int STALL_TICKS    = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk,
  input  logic w_clear_n,
  input  logic w_pause,
  input  logic r_clear_n,
  input  logic r_pause,
  output logic read_valid,
  output logic violation,
  output logic need_reset
);
  localparam int PW = $clog2(LINE_LEN);
  localparam int NSIDE = 2;  // index 0 = write, 1 = read

  side_ctl_t         ctl [NSIDE];
  logic [PW-1:0]     ptr [NSIDE];
  logic [PW:0]       diff;
  logic [PW:0]       lead;
  logic              too_close;
  logic              both_active;
  logic              rd_active;

  assign ctl[0] = '{clear_n: w_clear_n, pause: w_pause};
  assign ctl[1] = '{clear_n: r_clear_n, pause: r_pause};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    lmv_ptr #(.LINE_LEN(LINE_LEN)) u_ptr (
      .clk (clk),
      .rst (rst),
      .ctl (ctl[g]),
      .ptr (ptr[g])
    );
  end

  // Lead of write over read, modulo the line length.
  assign diff = {1'b0, ptr[0]} - {1'b0, ptr[1]};
  assign lead = diff[PW] ? diff + (PW+1)'(LINE_LEN) : diff;

  assign too_close   = (lead != '0) && (int'(lead) < MIN_GAP);
  assign both_active = side_active(ctl[0]) && side_active(ctl[1]);
  assign rd_active   = side_active(ctl[1]);

  lmv_recovery #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_recovery (
    .clk         (clk),
    .rst         (rst),
    .both_active (both_active),
    .rd_active   (rd_active),
    .too_close   (too_close),
    .need_reset  (need_reset),
    .read_valid  (read_valid),
    .violation   (violation)
  );

  // Reference-clock domain: reset and stall detection.
  logic ref_rst;
  logic stall_tgl;
  logic tgl_s;
  logic tgl_d;
  logic stall_evt;
  logic seen_w;
  logic seen_r;
  logic seen_w_nx;
  logic seen_r_nx;

  lmv_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ref_rst_sync (
    .clk (ref_clk),
    .rst (1'b0),
    .d   (rst),
    .q   (ref_rst)
  );

  lmv_stall_det #(.STALL_TICKS(STALL_TICKS)) u_stall (
    .ref_clk   (ref_clk),
    .ref_rst   (ref_rst),
    .mem_clk   (clk),
    .stall_tgl (stall_tgl)
  );

  lmv_sync #(.STAGES(2), .RST_VAL(1'b0)) u_tgl_sync (
    .clk (clk),
    .rst (rst),
    .d   (stall_tgl),
    .q   (tgl_s)
  );

  assign stall_evt = tgl_s ^ tgl_d;
  assign seen_w_nx = seen_w || !w_clear_n;
  assign seen_r_nx = seen_r || !r_clear_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_d      <= 1'b0;
      need_reset <= 1'b0;
      seen_w     <= 1'b0;
      seen_r     <= 1'b0;
    end else begin
      tgl_d <= tgl_s;
      if (stall_evt) begin
        need_reset <= 1'b1;
        seen_w     <= 1'b0;
        seen_r     <= 1'b0;
      end else if (need_reset) begin
        if (seen_w_nx && seen_r_nx) begin
          need_reset <= 1'b0;
          seen_w     <= 1'b0;
          seen_r     <= 1'b0;
        end else begin
          seen_w <= seen_w_nx;
          seen_r <= seen_r_nx;
        end
      end
    end
  end

  // R10: both clears in one cycle release the flag
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (need_reset && !w_clear_n && !r_clear_n && !stall_evt) |=> !need_reset);

  // R6: a paused or cleared side never starts a violation
  a_r6_exempt: assert property (@(posedge clk) disable iff (rst)
    !both_active |=> !violation);
endmodule

// File: tb/tb_line_mem_read_monitor.sv
`timescale 1ns/100ps
module tb_line_mem_read_monitor;
  localparam int L   = 1024;
  localparam int GAP = 256;
  localparam int REC = 256;

  logic clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic clk_run = 1'b1;
  logic w_clear_n = 1'b1, w_pause = 1'b1, r_clear_n = 1'b1, r_pause = 1'b1;
  logic read_valid, violation, need_reset;

  always #5 if (clk_run) clk = ~clk;
  always #3.5 ref_clk = ~ref_clk;

  line_mem_read_monitor #(.LINE_LEN(L), .MIN_GAP(GAP), .RECOVER_CYCLES(REC),
                          .STALL_TICKS(20)) dut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk),
    .w_clear_n(w_clear_n), .w_pause(w_pause),
    .r_clear_n(r_clear_n), .r_pause(r_pause),
    .read_valid(read_valid), .violation(violation), .need_reset(need_reset));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  int  mw = 0, mr = 0, mrec = 0;
  bit  mprev = 0, mneed = 0, msw = 0, msr = 0;
  bit  skip_need = 0;

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // One clock cycle: drive at negedge, model, compare at next negedge.
  task automatic step(bit wz, bit rz, bit ws, bit rs, string tag);
    bit act, ract, v, ev, eviol;
    int lead;
    w_clear_n = wz; r_clear_n = rz; w_pause = ws; r_pause = rs;
    act  = wz && rz && !ws && !rs;
    ract = rz && !rs;
    lead = (mw - mr + L) % L;
    v    = act && lead != 0 && lead < GAP;
    ev    = ract && !v && mrec == 0 && !mneed;
    eviol = v && !mprev;
    mprev = v;
    if (v) mrec = REC;
    else if (mrec > 0 && ract) mrec--;
    if (!wz) mw = 0; else if (!ws) mw = (mw + 1) % L;
    if (!rz) mr = 0; else if (!rs) mr = (mr + 1) % L;
    if (mneed) begin
      msw = msw || !wz;
      msr = msr || !rz;
      if (msw && msr) begin mneed = 0; msw = 0; msr = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "read_valid", read_valid, ev);
    chk(tag, "violation", violation, eviol);
    if (!skip_need) chk(tag, "need_reset", need_reset, mneed);
  endtask

  task automatic run(int n, bit wz, bit rz, bit ws, bit rs, string tag);
    for (int i = 0; i < n; i++) step(wz, rz, ws, rs, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "read_valid", read_valid, 1'b0);
    chk("R1", "violation", violation, 1'b0);
    chk("R1", "need_reset", need_reset, 1'b0);
    rst = 1'b0;
    step(1, 1, 1, 1, "R1");

    // R2: clear both, write alone, then both at a safe lead
    step(0, 0, 0, 0, "R2");
    run(300, 1, 1, 0, 1, "R11");
    run(300, 1, 1, 0, 0, "R2");

    // R6: write paused lets lead shrink without a hazard
    run(50, 1, 1, 1, 0, "R6");
    // R3/R4: both active at lead 250
    run(20, 1, 1, 0, 0, "R3");
    // R5: read paused during recovery does not count
    run(10, 1, 1, 0, 1, "R5");
    run(300, 1, 1, 0, 0, "R5");

    // R4: a broken run yields a second pulse
    run(10, 1, 1, 1, 0, "R6");
    run(5, 1, 1, 0, 0, "R4");
    step(1, 1, 0, 1, "R4");
    run(3, 1, 1, 0, 0, "R4");
    run(20, 1, 1, 0, 1, "R5");
    run(280, 1, 1, 0, 0, "R5");

    // R7: equal pointers, then read ahead
    step(0, 0, 0, 0, "R7");
    run(100, 1, 1, 0, 0, "R7");
    run(100, 1, 1, 1, 0, "R7");
    run(100, 1, 1, 0, 0, "R7");

    // R8: wrap of the lead across the line end
    while (mr != 1000) step(1, 1, 1, 0, "R8");
    step(0, 1, 1, 0, "R6");
    run(40, 1, 1, 0, 0, "R8");
    run(300, 1, 1, 0, 1, "R5");
    run(300, 1, 1, 0, 0, "R5");

    // R9: clock stall
    step(1, 1, 1, 1, "R9");
    clk_run = 1'b0;
    #400;
    clk_run = 1'b1;
    skip_need = 1;
    run(4, 1, 1, 1, 1, "R9");
    skip_need = 0;
    chk("R9", "need_reset", need_reset, 1'b1);
    mneed = 1; msw = 0; msr = 0;
    run(20, 1, 1, 0, 0, "R9");
    // R10: write clear, then read clear
    step(0, 1, 1, 1, "R10");
    run(3, 1, 1, 1, 1, "R10");
    step(1, 0, 1, 1, "R10");
    step(0, 0, 0, 0, "R10");
    run(50, 1, 1, 0, 0, "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule